// File: doc/BRIEF.md
# Static Memory Burst Read Controller

This block reads a short burst from an external asynchronous static memory or ROM. A host requests a burst with a one-cycle start pulse. With that pulse it gives a base address, an access size (halfword or word), a burst length, two wait-state counts and a sequential-mode flag. The block then drives the memory bus. It holds chip select and output enable low and steps the address after every beat. It returns each beat to the host with a one-cycle valid strobe.

Each beat can be stretched in two ways. The first is a programmed wait count. The first beat of a burst always uses the non-sequential count. Later beats use the sequential count when sequential mode is on, and the non-sequential count otherwise. The second is the external ready line. It is sampled on the falling clock edge just before the rising edge that would end a beat. Every low sample costs one more clock, and there is no upper limit. With sequential mode off, the block adds one recovery cycle after a burst before it accepts a new one. With sequential mode on, it can accept a new request in the cycle that reports completion.

Top module: `sram_burst_reader`

## Requirements
- R1: The burst length field `burst_len_i` is 3 bits wide and is latched when a start is accepted. Values 2, 3 and 4 give that many beats. Values 0 and 1 give 2 beats, and values 5 to 7 give 4 beats.
- R2: Cycle numbering: cycle 0 is the cycle after the rising edge that accepts a start. With both wait counts at zero and ready high, the first beat is captured at the end of cycle 1 and each later beat one cycle after the previous one (1-0-0-0). The valid strobe for a beat shows in the cycle after its capture edge.
- R3: A wait count of N adds N cycles to a beat. The first beat uses `ns_wait_i`. Each later beat uses `sq_wait_i` when `seq_en_i` was 1 at start, and `ns_wait_i` otherwise.
- R4: Ready is sampled on the falling clock edge. It matters only in a cycle where the beat's wait count has run out. A low sample there delays the capture by one cycle, and the line is sampled again in the next cycle. A low level during wait-count cycles has no effect.
- R5: `mem_addr_o` equals the base address in cycle 0. It increases by 4 for word accesses or by 2 for halfword accesses after each captured beat, and it holds its value in all other cycles.
- R6: `size_word_i` = 1 selects word access, which drives `mem_word_o`=1 and `mem_half_o`=0. `size_word_i` = 0 selects halfword access, which drives `mem_word_o`=0 and `mem_half_o`=1. The write indicator `mem_wr_o` stays 0 and the write strobe `mem_we_n_o` stays 1 at all times.
- R7: `mem_cs_n_o` and `mem_oe_n_o` go low in cycle 0 and stay low up to the edge that captures the final beat. Both are high in the cycle after that edge.
- R8: `rd_data_o` carries the value on `mem_rdata_i` at each capture edge, with `rd_valid_o` high for that one cycle. `done_o` is high together with the final beat's valid strobe.
- R9: `busy_o` is high from cycle 0 until the burst finishes. A start pulse while `busy_o` is high is ignored: the address sequence and the number of beats do not change, and no second burst follows.
- R10: With `seq_en_i`=0 at start, `busy_o` stays high for one cycle after `done_o`, and a start pulse in the `done_o` cycle is ignored. With `seq_en_i`=1, `busy_o` is low in the `done_o` cycle, and a start pulse in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst request, accepted while idle |
| base_addr_i | input | AW | First beat address |
| size_word_i | input | 1 | 1 = word, 0 = halfword |
| burst_len_i | input | 3 | Requested beat count |
| ns_wait_i | input | WW | Non-sequential wait count |
| sq_wait_i | input | WW | Sequential wait count |
| seq_en_i | input | 1 | Sequential mode enable |
| mem_rdata_i | input | DW | Memory read data |
| mem_rdy_i | input | 1 | External ready, high = transfer may complete |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write strobe, held inactive |
| mem_wr_o | output | 1 | Write indicator, held at read |
| mem_addr_o | output | AW | Memory address |
| mem_half_o | output | 1 | Halfword access indicator |
| mem_word_o | output | 1 | Word access indicator |
| rd_data_o | output | DW | Captured beat data |
| rd_valid_o | output | 1 | One-cycle strobe per beat |
| done_o | output | 1 | Pulse with the final beat |
| busy_o | output | 1 | Burst in progress |

## Verification
The first pattern is a zero-wait word burst, which pins down the bare 1-0-0-0 spacing. It is repeated in halfword form with non-zero wait counts, once in each sequential setting. This separates a design that picks the wrong wait field for later beats from one that counts correctly. A separate run lowers ready both during wait-count cycles and at the transfer point. This shows that ready is only acted on once the count has run out, and that each low sample adds exactly one cycle. Further runs cover the clamped length codes, a start pulse in the middle of a burst, and a start pulse in the done cycle under both modes. The last of these is the only pattern that tells the recovery cycle apart from back-to-back acceptance.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

   // Controller phases: address setup, beat transfer, recovery gap
   typedef enum logic [1:0] {
      SBR_IDLE = 2'd0,
      SBR_ADDR = 2'd1,
      SBR_BEAT = 2'd2,
      SBR_GAP  = 2'd3
   } sbr_state_e;

   localparam int unsigned SBR_HALF_BYTES = 2;
   localparam int unsigned SBR_WORD_BYTES = 4;

endpackage

// File: rtl/sbr_rdy_sampler.sv
module sbr_rdy_sampler #(
   parameter bit FALL_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rdy_i,
   output logic rdy_o
);

   generate
      if (FALL_EDGE) begin : g_fall
         logic rdy_q;
         // Half-cycle sample taken ahead of the deciding rising edge
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) rdy_q <= 1'b0;
            else        rdy_q <= rdy_i;
         end
         assign rdy_o = rdy_q;
      end else begin : g_rise
         // Ready observed directly at the deciding rising edge
         assign rdy_o = rdy_i;
      end
   endgenerate

endmodule

// File: rtl/sbr_wait_timer.sv
module sbr_wait_timer #(
   parameter int WW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [WW-1:0] load_val_i,
   output logic          expired_o
);

   logic [WW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (load_i)           cnt_q <= load_val_i;
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sbr_addr_gen.sv
module sbr_addr_gen #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] base_i,
   input  logic          adv_i,
   input  logic          word_i,
   output logic [AW-1:0] addr_o
);

   import sbr_pkg::*;

   localparam logic [AW-1:0] STEP_HALF = AW'(SBR_HALF_BYTES);
   localparam logic [AW-1:0] STEP_WORD = AW'(SBR_WORD_BYTES);

   logic [AW-1:0] addr_q;
   logic [AW-1:0] step;

   assign step = word_i ? STEP_WORD : STEP_HALF;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (load_i) addr_q <= base_i;
      else if (adv_i)  addr_q <= addr_q + step;
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/sbr_beat_fsm.sv
module sbr_beat_fsm #(
   parameter int MIN_BEATS = 2,
   parameter int MAX_BEATS = 4,
   parameter int LENW      = 3,
   parameter int WW        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LENW-1:0]   len_i,
   input  logic              word_i,
   input  logic              seq_en_i,
   input  logic [WW-1:0]     ns_wait_i,
   input  logic [WW-1:0]     sq_wait_i,
   input  logic              timer_expired_i,
   input  logic              rdy_i,
   output sbr_pkg::sbr_state_e state_o,
   output logic              accept_o,
   output logic              timer_load_o,
   output logic [WW-1:0]     timer_val_o,
   output logic              beat_done_o,
   output logic              last_o,
   output logic              word_o
);

   import sbr_pkg::*;

   localparam logic [LENW-1:0] LEN_LO = LENW'(MIN_BEATS);
   localparam logic [LENW-1:0] LEN_HI = LENW'(MAX_BEATS);

   function automatic logic [LENW-1:0] clamp_len(input logic [LENW-1:0] v);
      if (v < LEN_LO)      return LEN_LO;
      else if (v > LEN_HI) return LEN_HI;
      else                 return v;
   endfunction

   sbr_state_e      state_q, state_d;
   logic [LENW-1:0] len_q;
   logic [LENW-1:0] beat_q;
   logic [WW-1:0]   ns_q, sq_q;
   logic            seq_q, word_q;

   assign accept_o    = (state_q == SBR_IDLE) && start_i;
   assign beat_done_o = (state_q == SBR_BEAT) && timer_expired_i && rdy_i;
   assign last_o      = (beat_q == LENW'(len_q - 1'b1));

   // First beat loads at the end of the address phase, later beats on completion
   assign timer_load_o = (state_q == SBR_ADDR) || (beat_done_o && !last_o);
   assign timer_val_o  = (state_q == SBR_ADDR) ? ns_q : (seq_q ? sq_q : ns_q);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SBR_IDLE: if (start_i) state_d = SBR_ADDR;
         SBR_ADDR: state_d = SBR_BEAT;
         SBR_BEAT: if (beat_done_o && last_o) state_d = seq_q ? SBR_IDLE : SBR_GAP;
         SBR_GAP:  state_d = SBR_IDLE;
         default:  state_d = SBR_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SBR_IDLE;
         len_q   <= LEN_LO;
         beat_q  <= '0;
         ns_q    <= '0;
         sq_q    <= '0;
         seq_q   <= 1'b0;
         word_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept_o) begin
            len_q  <= clamp_len(len_i);
            beat_q <= '0;
            ns_q   <= ns_wait_i;
            sq_q   <= sq_wait_i;
            seq_q  <= seq_en_i;
            word_q <= word_i;
         end else if (beat_done_o) begin
            beat_q <= beat_q + 1'b1;
         end
      end
   end

   assign state_o = state_q;
   assign word_o  = word_q;

endmodule

// File: rtl/sram_burst_reader.sv
module sram_burst_reader #(
   parameter int AW          = 16,
   parameter int DW          = 32,
   parameter int WW          = 4,
   parameter int MIN_BEATS   = 2,
   parameter int MAX_BEATS   = 4,
   parameter bit RDY_ON_FALL = 1'b1,
   localparam int LENW       = $clog2(MAX_BEATS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [AW-1:0]   base_addr_i,
   input  logic            size_word_i,
   input  logic [LENW-1:0] burst_len_i,
   input  logic [WW-1:0]   ns_wait_i,
   input  logic [WW-1:0]   sq_wait_i,
   input  logic            seq_en_i,
   input  logic [DW-1:0]   mem_rdata_i,
   input  logic            mem_rdy_i,
   output logic            mem_cs_n_o,
   output logic            mem_oe_n_o,
   output logic            mem_we_n_o,
   output logic            mem_wr_o,
   output logic [AW-1:0]   mem_addr_o,
   output logic            mem_half_o,
   output logic            mem_word_o,
   output logic [DW-1:0]   rd_data_o,
   output logic            rd_valid_o,
   output logic            done_o,
   output logic            busy_o
);

   import sbr_pkg::*;

   // Elaboration-time parameter checks
   generate
      if (MIN_BEATS < 1 || MAX_BEATS < MIN_BEATS)
         $error("sram_burst_reader: beat range is empty");
      if (AW < 3)
         $error("sram_burst_reader: address too narrow for word stepping");
      if (WW < 1 || DW < 1)
         $error("sram_burst_reader: wait or data width must be positive");
   endgenerate

   sbr_state_e    state;
   logic          accept, t_load, t_expired, beat_done, last, word_q, rdy_s;
   logic [WW-1:0] t_val;
   logic [DW-1:0] data_q;
   logic          valid_q, done_q;

   sbr_rdy_sampler #(.FALL_EDGE(RDY_ON_FALL)) u_rdy (
      .clk   (clk),
      .rst_n (rst_n),
      .rdy_i (mem_rdy_i),
      .rdy_o (rdy_s)
   );

   sbr_beat_fsm #(
      .MIN_BEATS (MIN_BEATS),
      .MAX_BEATS (MAX_BEATS),
      .LENW      (LENW),
      .WW        (WW)
   ) u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .start_i         (start_i),
      .len_i           (burst_len_i),
      .word_i          (size_word_i),
      .seq_en_i        (seq_en_i),
      .ns_wait_i       (ns_wait_i),
      .sq_wait_i       (sq_wait_i),
      .timer_expired_i (t_expired),
      .rdy_i           (rdy_s),
      .state_o         (state),
      .accept_o        (accept),
      .timer_load_o    (t_load),
      .timer_val_o     (t_val),
      .beat_done_o     (beat_done),
      .last_o          (last),
      .word_o          (word_q)
   );

   sbr_wait_timer #(.WW(WW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (t_load),
      .load_val_i (t_val),
      .expired_o  (t_expired)
   );

   sbr_addr_gen #(.AW(AW)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .base_i (base_addr_i),
      .adv_i  (beat_done),
      .word_i (word_q),
      .addr_o (mem_addr_o)
   );

   // Beat capture on the rising edge that closes each transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         valid_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         valid_q <= beat_done;
         done_q  <= beat_done && last;
         if (beat_done) data_q <= mem_rdata_i;
      end
   end

   assign mem_cs_n_o = !((state == SBR_ADDR) || (state == SBR_BEAT));
   assign mem_oe_n_o = mem_cs_n_o;
   assign mem_we_n_o = 1'b1;
   assign mem_wr_o   = 1'b0;
   assign mem_half_o = !word_q;
   assign mem_word_o = word_q;
   assign rd_data_o  = data_q;
   assign rd_valid_o = valid_q;
   assign done_o     = done_q;
   assign busy_o     = (state != SBR_IDLE);

endmodule

// File: rtl/sbr_chk.sv
module sbr_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_cs_n,
   input logic          mem_oe_n,
   input logic [AW-1:0] mem_addr,
   input logic          mem_half,
   input logic          mem_word,
   input logic          rd_valid,
   input logic          done,
   input logic          busy
);

   // R7
   cs_oe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs_n == mem_oe_n);

   // R7
   cs_release_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> mem_cs_n);

   // R8
   done_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> rd_valid);

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> mem_addr == $past(mem_addr) + AW'(mem_word ? 4 : 2));

   // R5
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !rd_valid) |-> $stable(mem_addr));

   // R6
   size_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_half != mem_word);

endmodule

bind sram_burst_reader sbr_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_cs_n (mem_cs_n_o),
   .mem_oe_n (mem_oe_n_o),
   .mem_addr (mem_addr_o),
   .mem_half (mem_half_o),
   .mem_word (mem_word_o),
   .rd_valid (rd_valid_o),
   .done     (done_o),
   .busy     (busy_o)
);

// File: tb/sram_burst_reader_tb.sv
`timescale 1ns/1ps
module sram_burst_reader_tb;

   localparam int AW = 16;
   localparam int DW = 32;
   localparam int WW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] base = '0;
   logic          word = 1'b0;
   logic [2:0]    blen = 3'd2;
   logic [WW-1:0] nsw = '0, sqw = '0;
   logic          seq = 1'b0;
   logic [DW-1:0] rdata;
   logic          rdy = 1'b1;
   logic          cs_n, oe_n, we_n, wr, half, wd, valid, done, busy;
   logic [AW-1:0] addr;
   logic [DW-1:0] rd;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   // Memory model: data is a fixed function of the address
   function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
      return {~a, a};
   endfunction
   assign rdata = mem_val(addr);

   sram_burst_reader #(.AW(AW), .DW(DW), .WW(WW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base),
      .size_word_i(word), .burst_len_i(blen), .ns_wait_i(nsw), .sq_wait_i(sqw),
      .seq_en_i(seq), .mem_rdata_i(rdata), .mem_rdy_i(rdy),
      .mem_cs_n_o(cs_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_wr_o(wr),
      .mem_addr_o(addr), .mem_half_o(half), .mem_word_o(wd),
      .rd_data_o(rd), .rd_valid_o(valid), .done_o(done), .busy_o(busy)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic test_reset();
      chk(cs_n == 1'b1, "R7", "reset cs_n", cs_n, 1);
      chk(oe_n == 1'b1, "R7", "reset oe_n", oe_n, 1);
      chk(we_n == 1'b1 && wr == 1'b0, "R6", "reset write pins", {we_n, wr}, 2'b10);
      chk(busy == 1'b0, "R9", "reset busy", busy, 0);
      chk(valid == 1'b0 && done == 1'b0, "R8", "reset strobes", {valid, done}, 0);
   endtask

   // Runs one burst; stl holds one stall nibble per beat, wlow lowers ready
   // during wait-count cycles, probe pulses start mid-burst.
   task automatic run_burst(input string tag, input logic [AW-1:0] b, input bit w,
                            input logic [2:0] lf, input int nb, input int nw,
                            input int sw, input bit sq, input logic [15:0] stl,
                            input bit wlow, input bit probe);
      int att[4];
      int cap[4];
      int beg[4];
      int cur;
      int last;
      int stp;
      stp = w ? 4 : 2;
      cur = 1;
      for (int k = 0; k < nb; k++) begin
         beg[k] = cur;
         att[k] = cur + (((k == 0) || !sq) ? nw : sw);
         cap[k] = att[k] + int'(stl[k*4 +: 4]) + 1;
         cur = cap[k];
      end
      last = cap[nb-1];
      base = b; word = w; blen = lf; nsw = WW'(nw); sqw = WW'(sw); seq = sq;
      start = 1'b1;
      for (int c = 0; c <= last; c++) begin
         int idx;
         bit lo;
         bit ev;
         int ek;
         step();
         start = 1'b0;
         if (probe && c == 2) begin
            start = 1'b1;
            base = b ^ 16'h0F00;
            blen = 3'd4;
         end
         lo = 1'b0;
         for (int k = 0; k < nb; k++) begin
            if (c >= att[k] && c < att[k] + int'(stl[k*4 +: 4])) lo = 1'b1;
            if (wlow && c >= beg[k] && c < att[k]) lo = 1'b1;
         end
         rdy = !lo;
         ev = 1'b0; ek = 0; idx = 0;
         for (int k = 0; k < nb; k++) begin
            if (c == cap[k]) begin ev = 1'b1; ek = k; end
            if (cap[k] <= c) idx++;
         end
         chk(cs_n == (c >= last), tag, "R7 cs_n", cs_n, (c >= last));
         chk(oe_n == (c >= last), tag, "R7 oe_n", oe_n, (c >= last));
         chk(valid == ev, tag, "R8/R2/R3/R4 valid timing", valid, ev);
         if (ev) begin
            chk(rd == mem_val(AW'(b + ek * stp)), tag, "R8 data", rd,
                mem_val(AW'(b + ek * stp)));
            chk(done == (ek == nb - 1), tag, "R8 done", done, (ek == nb - 1));
         end else begin
            chk(done == 1'b0, tag, "R8 done idle", done, 0);
         end
         if (c < last) begin
            chk(addr == AW'(b + idx * stp), tag, "R5 address", addr, AW'(b + idx * stp));
            chk(wd == w && half == !w, tag, "R6 size", {wd, half}, {w, !w});
            chk(we_n == 1'b1 && wr == 1'b0, tag, "R6 write pins", {we_n, wr}, 2'b10);
            chk(busy == 1'b1, tag, "R9 busy", busy, 1);
         end
      end
      rdy = 1'b1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic test_zero_wait();
      run_burst("R2 zero-wait word x4", 16'h0100, 1'b1, 3'd4, 4, 0, 0, 1'b1,
                16'h0000, 1'b0, 1'b0);
      idle(2);
   endtask

   task automatic test_waits();
      run_burst("R3 half x3 ns2 seq-off", 16'h0200, 1'b0, 3'd3, 3, 2, 1, 1'b0,
                16'h0000, 1'b0, 1'b0);
      idle(2);
      run_burst("R3 half x3 ns2 sq1 seq-on", 16'h0210, 1'b0, 3'd3, 3, 2, 1, 1'b1,
                16'h0000, 1'b0, 1'b0);
      idle(2);
   endtask

   task automatic test_ready();
      run_burst("R4 stalls", 16'h0300, 1'b1, 3'd4, 4, 1, 0, 1'b1,
                16'h0302, 1'b1, 1'b0);
      idle(2);
      run_burst("R4 long stall", 16'h0340, 1'b0, 3'd2, 2, 0, 0, 1'b0,
                16'h009F, 1'b0, 1'b0);
      idle(2);
   endtask

   task automatic test_clamp();
      run_burst("R1 len0", 16'h0400, 1'b1, 3'd0, 2, 0, 0, 1'b1, 16'h0, 1'b0, 1'b0);
      idle(2);
      run_burst("R1 len1", 16'h0410, 1'b0, 3'd1, 2, 0, 0, 1'b1, 16'h0, 1'b0, 1'b0);
      idle(2);
      run_burst("R1 len5", 16'h0420, 1'b1, 3'd5, 4, 0, 0, 1'b1, 16'h0, 1'b0, 1'b0);
      idle(2);
      run_burst("R1 len7", 16'h0440, 1'b0, 3'd7, 4, 0, 1, 1'b1, 16'h0, 1'b0, 1'b0);
      idle(2);
   endtask

   task automatic test_ignore();
      run_burst("R9 mid-burst start", 16'h0500, 1'b1, 3'd3, 3, 1, 1, 1'b0,
                16'h0010, 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) begin
         step();
         chk(cs_n == 1'b1, "R9", "no second burst cs_n", cs_n, 1);
         chk(valid == 1'b0, "R9", "no second burst valid", valid, 0);
      end
   endtask

   task automatic test_gap(input bit sq);
      run_burst(sq ? "R10 seq-on" : "R10 seq-off", 16'h0600, 1'b1, 3'd2, 2, 0, 0,
                sq, 16'h0, 1'b0, 1'b0);
      chk(busy == !sq, "R10", "busy in done cycle", busy, !sq);
      base = 16'h0700; blen = 3'd2; nsw = '0; sqw = '0;
      start = 1'b1;
      step();
      start = 1'b0;
      chk(cs_n == !sq, "R10", "cs_n after done-cycle start", cs_n, !sq);
      if (sq) begin
         chk(addr == 16'h0700, "R10", "new base accepted", addr, 16'h0700);
      end else begin
         step();
         chk(busy == 1'b0 && cs_n == 1'b1, "R10", "recovery over, start dropped",
             {busy, cs_n}, 2'b01);
      end
      idle(6);
      chk(busy == 1'b0, "R10", "idle after", busy, 0);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      idle(3);
      test_reset();
      rst_n = 1'b1;
      idle(2);
      test_zero_wait();
      test_waits();
      test_ready();
      test_clamp();
      test_ignore();
      test_gap(1'b0);
      test_gap(1'b1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule